// File: doc/BRIEF.md
# SPI Mode-0 Serial Memory Slave Front-End

This block sits between the pins of an SPI-attached memory device and its command decoder. It watches chip select, serial clock, serial data in and a hold pin, all brought into the system clock domain through a synchronizer. Incoming bits are assembled MSB first on serial clock rising edges. Each completed byte goes to the decoder as a one-cycle strobe, together with its position in the frame: 0 is the instruction, then come address bytes, then data. When chip select returns high, an end-of-frame strobe reports whether the frame closed on a whole byte.

For reads, the decoder raises a level request once it knows data must flow back. At the next byte boundary the block takes a byte from the decoder, confirms the take with a pulse, and shifts it out MSB first on falling serial clock edges. A low hold input, seen while the serial clock is low, freezes the transfer in place: clock edges are ignored, the output is released, and the transfer resumes from the same bit when hold goes high again, also seen while the clock is low.

The control state machine has five states. IDLE means deselected. RECV means selected, receiving only. SEND means selected and driving read data. PAUSE_RECV and PAUSE_SEND mean held, remembering which of the two active states to return to. The transitions are named as follows:
- START: IDLE to RECV, on a chip select fall.
- TURN: RECV to SEND, on a serial clock fall at a byte boundary, after at least one byte, with the read request high.
- FREEZE: RECV or SEND to its pause state, when hold is low while the clock is low.
- THAW: a pause state back to its active state, when hold is high while the clock is low.
- STOP: any state other than IDLE to IDLE, on a chip select rise.

Top module: `spi_mem_frontend`

## Requirements
- R1: In RECV or SEND, each serial clock rising edge samples data in. After every 8 sampled bits, `rx_valid` pulses for one cycle, and `rx_byte` holds those bits with the first-sampled bit in bit 7.
- R2: `rx_index` gives the number of whole bytes received earlier in the frame: 0 for the first byte. It saturates at 2^IDX_W-1, which is 15 by default.
- R3: In SEND, the output `spi_miso` changes only after a serial clock falling edge. At each byte boundary it starts a new byte from `tx_data`, with `tx_load` pulsing for one cycle, and then gives bit 7 down to bit 0 on successive falling edges.
- R4: `spi_miso_oe` is high only in SEND. SEND is entered only on a falling edge that follows a whole byte, with at least one byte in the frame and `tx_enable` high. A frame with `tx_enable` low never drives.
- R5: After chip select rises, `spi_miso_oe` is low, and it stays low until a later frame enters SEND.
- R6: Each chip select rise ending a frame gives one `frame_end` pulse. `frame_whole` is 1 if no partial byte was pending and 0 otherwise.
- R7: A chip select fall clears the bit and byte counters. Bits of a partial byte from an aborted frame are discarded, and the next frame's first byte has index 0.
- R8: Hold low, seen while the serial clock is low, pauses the transfer. Clock edges are then ignored (no bits counted, no output shift), and `spi_miso_oe` is low. Hold asserted while the clock is high takes effect only once the clock is low. The edge in progress is still counted.
- R9: Hold high, seen while the clock is low, resumes in the state that was paused, at the same bit position. Output drive returns in a read.
- R10: After reset, `spi_miso_oe`, `rx_valid`, `frame_end` and `tx_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 (idles low) |
| spi_mosi | input | 1 | Serial data into the device |
| spi_hold_n | input | 1 | Hold, active low |
| spi_miso | output | 1 | Serial data out (meaningful when enabled) |
| spi_miso_oe | output | 1 | Output enable for the data pin; low means high impedance |
| rx_valid | output | 1 | One-cycle strobe: a byte was received |
| rx_byte | output | 8 | Received byte |
| rx_index | output | IDX_W | Position of the byte within the frame |
| frame_end | output | 1 | One-cycle strobe: chip select rose |
| frame_whole | output | 1 | With frame_end: frame ended on a byte boundary |
| tx_enable | input | 1 | Decoder request to enter the read-data phase |
| tx_data | input | 8 | Next byte to shift out |
| tx_load | output | 1 | One-cycle strobe: tx_data was taken |

## Verification
The main function is tried with a plain multi-byte write frame, a read frame where the read request arrives after the third byte, and a frame long enough to run the byte index into saturation. Together these separate bit ordering, index counting and turn-around timing. An aborted frame with three stray bits, followed by a fresh frame, distinguishes a counter cleared at frame start from one that carries leftover bits. Hold is applied at a low clock in a write, at a low clock during read data, and while the clock is high. Toggling the clock during each pause separates a pause that ignores edges from one that miscounts them, and shows that the output enable drops and returns.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_SEND,
        ST_PAUSE_RECV,
        ST_PAUSE_SEND
    } fe_state_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int              W      = 4,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{INIT[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_in[b]};
            end
        end
        assign d_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sck_s,
    input  logic hold_s,
    input  logic tx_enable,
    input  logic bit_zero,
    input  logic any_byte,
    output logic frame_start,
    output logic frame_stop,
    output logic rise_evt,
    output logic fall_evt,
    output logic load_evt,
    output logic shift_evt,
    output logic miso_oe,
    output logic paused
);

    fe_state_t state_q;
    fe_state_t state_d;
    logic      cs_prev;
    logic      sck_prev;
    logic      cs_fall;
    logic      cs_rise;
    logic      sck_r;
    logic      sck_f;
    logic      active;
    logic      hold_req;
    logic      hold_rel;
    logic      turn_ok;

    assign cs_fall  = cs_prev & ~cs_s;
    assign cs_rise  = ~cs_prev & cs_s;
    assign sck_r    = sck_s & ~sck_prev;
    assign sck_f    = ~sck_s & sck_prev;
    assign hold_req = ~hold_s & ~sck_s;
    assign hold_rel = hold_s & ~sck_s;
    assign turn_ok  = sck_f & bit_zero & any_byte & tx_enable;

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_RECV;
            end
            ST_RECV: begin
                if (cs_rise)       state_d = ST_IDLE;
                else if (turn_ok)  state_d = ST_SEND;
                else if (hold_req) state_d = ST_PAUSE_RECV;
            end
            ST_SEND: begin
                if (cs_rise)       state_d = ST_IDLE;
                else if (hold_req) state_d = ST_PAUSE_SEND;
            end
            ST_PAUSE_RECV: begin
                if (cs_rise)       state_d = ST_IDLE;
                else if (hold_rel) state_d = ST_RECV;
            end
            ST_PAUSE_SEND: begin
                if (cs_rise)       state_d = ST_IDLE;
                else if (hold_rel) state_d = ST_SEND;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active      = (state_q == ST_RECV) || (state_q == ST_SEND);
        paused      = (state_q == ST_PAUSE_RECV) || (state_q == ST_PAUSE_SEND);
        frame_start = (state_q == ST_IDLE) && cs_fall;
        frame_stop  = (state_q != ST_IDLE) && cs_rise;
        rise_evt    = active && sck_r && !cs_rise;
        fall_evt    = active && sck_f && !cs_rise;
        load_evt    = fall_evt && bit_zero &&
                      ((state_q == ST_SEND) ||
                       ((state_q == ST_RECV) && any_byte && tx_enable));
        shift_evt   = fall_evt && (state_q == ST_SEND) && !bit_zero;
        miso_oe     = (state_q == ST_SEND);
    end

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stop,
    input  logic              rise_evt,
    input  logic              mosi_s,
    output logic              bit_zero,
    output logic              any_byte,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic [IDX_W-1:0]  rx_index,
    output logic              frame_end,
    output logic              frame_whole
);

    localparam int                CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  IDX_MAX  = '1;

    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_cnt;
    logic [DATA_W-2:0] sr;
    logic [DATA_W-1:0] word_in;

    assign word_in  = {sr, mosi_s};
    assign bit_zero = (bit_cnt == '0);
    assign any_byte = (byte_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            byte_cnt    <= '0;
            sr          <= '0;
            rx_valid    <= 1'b0;
            rx_byte     <= '0;
            rx_index    <= '0;
            frame_end   <= 1'b0;
            frame_whole <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_end <= 1'b0;
            if (clear) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else if (rise_evt) begin
                sr <= word_in[DATA_W-2:0];
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_byte  <= word_in;
                    rx_index <= byte_cnt;
                    if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (stop) begin
                frame_end   <= 1'b1;
                frame_whole <= bit_zero;
            end
        end
    end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_evt,
    input  logic              shift_evt,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso_bit,
    output logic              tx_load
);

    logic [DATA_W-1:0] sr;

    assign miso_bit = sr[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= load_evt;
            if (load_evt)       sr <= tx_data;
            else if (shift_evt) sr <= {sr[DATA_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic [IDX_W-1:0]  rx_index,
    output logic              frame_end,
    output logic              frame_whole,
    input  logic              tx_enable,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_load
);

    localparam int         PIN_W    = 4;
    localparam logic [3:0] PIN_INIT = 4'b1001;

    logic [PIN_W-1:0] pins_raw;
    logic [PIN_W-1:0] pins_s;
    logic cs_s, sck_s, mosi_s, hold_s;
    logic frame_start, frame_stop, rise_evt, fall_evt;
    logic load_evt, shift_evt, paused, bit_zero, any_byte, miso_bit, oe;

    assign pins_raw = {spi_hold_n, spi_mosi, spi_sck, spi_cs_n};
    assign {hold_s, mosi_s, sck_s, cs_s} = pins_s;

    spi_fe_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_INIT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .d_out (pins_s)
    );

    spi_fe_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sck_s       (sck_s),
        .hold_s      (hold_s),
        .tx_enable   (tx_enable),
        .bit_zero    (bit_zero),
        .any_byte    (any_byte),
        .frame_start (frame_start),
        .frame_stop  (frame_stop),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .load_evt    (load_evt),
        .shift_evt   (shift_evt),
        .miso_oe     (oe),
        .paused      (paused)
    );

    spi_fe_rx #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (frame_start),
        .stop        (frame_stop),
        .rise_evt    (rise_evt),
        .mosi_s      (mosi_s),
        .bit_zero    (bit_zero),
        .any_byte    (any_byte),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .rx_index    (rx_index),
        .frame_end   (frame_end),
        .frame_whole (frame_whole)
    );

    spi_fe_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_evt  (load_evt),
        .shift_evt (shift_evt),
        .tx_data   (tx_data),
        .miso_bit  (miso_bit),
        .tx_load   (tx_load)
    );

    assign spi_miso_oe = oe;
    assign spi_miso    = oe & miso_bit;

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk (
    input logic clk,
    input logic rst_n,
    input logic paused,
    input logic fall_evt,
    input logic miso,
    input logic miso_oe,
    input logic rx_valid,
    input logic frame_end,
    input logic tx_load
);

    // R1
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R8
    pause_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> !rx_valid);

    // R8
    pause_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !miso_oe);

    // R3
    load_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> miso_oe);

    // R4
    turn_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(miso_oe) && !$past(paused)) |-> tx_load);

    // R3
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$past(fall_evt)) |-> $stable(miso));

endmodule

bind spi_mem_frontend spi_fe_chk u_spi_fe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .paused    (paused),
    .fall_evt  (fall_evt),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .rx_valid  (rx_valid),
    .frame_end (frame_end),
    .tx_load   (tx_load)
);

// File: tb/test_spi_mem_frontend.sv
`timescale 1ns/1ps
module test_spi_mem_frontend;

    localparam int IDX_W   = 4;
    localparam int IDX_MAX = (1 << IDX_W) - 1;
    localparam int HALF    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, spi_hold_n = 1'b1;
    logic       spi_miso, spi_miso_oe, rx_valid, frame_end, frame_whole, tx_load;
    logic [7:0] rx_byte;
    logic [IDX_W-1:0] rx_index;
    logic       tx_enable = 1'b0;
    logic [7:0] tx_data = 8'h00;

    always #4 clk = ~clk;

    spi_mem_frontend #(.DATA_W(8), .IDX_W(IDX_W)) i_spi_mem_frontend (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_index(rx_index), .frame_end(frame_end), .frame_whole(frame_whole),
        .tx_enable(tx_enable), .tx_data(tx_data), .tx_load(tx_load)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_byte_q[$];
    int         exp_idx_q[$];
    bit         exp_whole_q[$];

    // reference state of the bench
    int         frame_bytes;
    bit         read_armed;
    bit         rd_on;
    int         rd_k;
    logic [7:0] rd_first;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison against the expected queues
    logic [7:0] eb;
    int         ei;
    bit         ew;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_byte_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected rx_valid", rx_byte, 0);
                end else begin
                    eb = exp_byte_q.pop_front();
                    ei = exp_idx_q.pop_front();
                    check(rx_byte == eb, "R1", "rx_byte", rx_byte, eb);
                    check(int'(rx_index) == ei, "R2", "rx_index", rx_index, ei);
                end
            end
            if (frame_end) begin
                if (exp_whole_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected frame_end", 1, 0);
                end else begin
                    ew = exp_whole_q.pop_front();
                    check(frame_whole == ew, "R6", "frame_whole", frame_whole, ew);
                end
            end
        end
    end

    // downstream decoder model
    always @(negedge clk) begin
        if (rx_valid && read_armed && rx_index == 2) tx_enable <= 1'b1;
        if (frame_end) tx_enable <= 1'b0;
        if (tx_load) tx_data <= tx_data + 8'h11;
    end

    task automatic hold_body();
        wait_clk(HALF);
        check(spi_miso_oe == 1'b0, "R8", "oe while held", spi_miso_oe, 0);
        for (int t = 0; t < 3; t++) begin
            spi_mosi = t[0];
            wait_clk(HALF);
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        check(spi_miso_oe == 1'b0, "R8", "oe after clocks in hold", spi_miso_oe, 0);
        spi_hold_n = 1'b1;
        wait_clk(HALF);
        check(spi_miso_oe == rd_on, "R9", "oe after release", spi_miso_oe, rd_on);
    endtask

    // one bit; hold_hi asserts hold during the high phase
    task automatic sck_bit(input logic b, input bit hold_hi);
        logic [7:0] exp_rd;
        int         pos;
        spi_mosi = b;
        wait_clk(HALF);
        if (rd_on) begin
            exp_rd = rd_first + 8'(8'h11 * rd_k);
            pos    = 7 - (frame_bits_in_byte % 8);
            check(spi_miso_oe == 1'b1, "R4", "oe in read", spi_miso_oe, 1);
            check(spi_miso == exp_rd[pos], "R3", "miso bit", spi_miso, exp_rd[pos]);
        end else begin
            check(spi_miso_oe == 1'b0, "R4", "oe outside read", spi_miso_oe, 0);
        end
        spi_sck = 1'b1;
        wait_clk(HALF / 2);
        if (hold_hi) spi_hold_n = 1'b0;
        wait_clk(HALF - HALF / 2);
        spi_sck = 1'b0;
        frame_bits_in_byte++;
    endtask

    int frame_bits_in_byte;

    // hold_at: bit position before which hold pauses (-1 none);
    // late: hold asserted in the high phase of that bit instead
    task automatic send_byte(input logic [7:0] v, input int hold_at, input bit late);
        exp_byte_q.push_back(v);
        exp_idx_q.push_back(frame_bytes > IDX_MAX ? IDX_MAX : frame_bytes);
        frame_bits_in_byte = 0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at && !late) begin
                spi_hold_n = 1'b0;
                hold_body();
            end
            sck_bit(v[i], (i == hold_at) && late);
            if (i == hold_at && late) hold_body();
        end
        frame_bytes++;
        if (rd_on) rd_k++;
        if (read_armed && frame_bytes == 3) rd_on = 1'b1;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        frame_bits_in_byte = 0;
        for (int i = 7; i > 7 - n; i--) sck_bit(v[i], 1'b0);
    endtask

    task automatic cs_low();
        frame_bytes = 0;
        rd_on = 1'b0;
        rd_k = 0;
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high(input bit whole);
        exp_whole_q.push_back(whole);
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        rd_on = 1'b0;
        wait_clk(2 * HALF);
        check(spi_miso_oe == 1'b0, "R5", "oe deselected", spi_miso_oe, 0);
        read_armed = 1'b0;
    endtask

    initial begin
        read_armed = 1'b0;
        rd_on = 1'b0;
        rd_k = 0;
        rd_first = 8'h00;
        frame_bytes = 0;
        frame_bits_in_byte = 0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R10 reset state
        check(spi_miso_oe == 1'b0, "R10", "oe after reset", spi_miso_oe, 0);
        check(rx_valid == 1'b0, "R10", "rx_valid after reset", rx_valid, 0);
        check(frame_end == 1'b0, "R10", "frame_end after reset", frame_end, 0);
        check(tx_load == 1'b0, "R10", "tx_load after reset", tx_load, 0);

        // R1 R2 R4 plain write frame
        cs_low();
        send_byte(8'h02, -1, 1'b0);
        send_byte(8'h00, -1, 1'b0);
        send_byte(8'h10, -1, 1'b0);
        send_byte(8'hAA, -1, 1'b0);
        send_byte(8'h55, -1, 1'b0);
        cs_high(1'b1);

        // R3 R4 R9 read frame with hold during read data
        read_armed = 1'b1;
        rd_first = 8'h5A;
        tx_data = 8'h5A;
        cs_low();
        send_byte(8'h03, -1, 1'b0);
        send_byte(8'h00, -1, 1'b0);
        send_byte(8'h20, -1, 1'b0);
        send_byte(8'h00, -1, 1'b0);
        send_byte(8'h00, 4, 1'b0);
        send_byte(8'h00, -1, 1'b0);
        cs_high(1'b1);

        // R6 R7 aborted frame, then fresh frame
        cs_low();
        send_bits(8'hA5, 3);
        cs_high(1'b0);
        cs_low();
        send_byte(8'h3C, -1, 1'b0);
        cs_high(1'b1);

        // R8 R9 hold in a write at low clock, then asserted while clock high
        cs_low();
        send_byte(8'hC3, 5, 1'b0);
        send_byte(8'h96, 3, 1'b1);
        cs_high(1'b1);

        // R2 index saturation
        cs_low();
        for (int k = 0; k < IDX_MAX + 3; k++) send_byte(8'(k * 7 + 1), -1, 1'b0);
        cs_high(1'b1);

        wait_clk(10);
        check(exp_byte_q.size() == 0, "R1", "bytes missing", exp_byte_q.size(), 0);
        check(exp_whole_q.size() == 0, "R6", "frame ends missing", exp_whole_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule